// File: doc/BRIEF.md
# Latched Three-Port Bus Exchanger

The block joins a processor-side port A to two memory-side ports, B1 and B2, each 12 bits wide by default. Four level-sensitive holding paths carry data: two outbound (A to B1, A to B2) and two inbound (B1 to A, B2 to A). Opening both outbound paths at once copies one A word onto both memory ports, which suits interleaved banks. Opening them in turn lets a multiplexed address be split across the two ports. A select input chooses which inbound path reaches A.

Each path is transparent while its enable is high, and it also samples its input on every clock edge. When the enable drops, the path keeps the value it sampled on the last clock edge while the enable was high. Each port has its own active-low output enable. A port that is disabled drives zero and deasserts its drive-enable flag.

Each port input passes through a keeper. While no external driver is active, the keeper supplies the last value that was driven. The keeper clears to zero at reset. Outbound paths read the keeper-resolved input of port A, and inbound paths read the keeper-resolved inputs of B1 and B2. A port's own output never feeds back into its paths.

Top module: `bus_xchg3`

## Requirements
- R1: While `le_a_b1` is high and `b1_oe_n` is low, `b1_out` equals the resolved A input in the same cycle.
- R2: After an enable falls, the path output holds the value sampled on the last rising clock edge at which the enable was high, whatever its input does afterwards.
- R3: With `le_a_b1` and `le_a_b2` both high and both B ports enabled, `b1_out` and `b2_out` both equal the resolved A input.
- R4: When `a_src_b1` is 1, `a_out` comes from the B1-to-A path. When it is 0, `a_out` comes from the B2-to-A path.
- R5: The inbound paths, enabled by `le_b1_a` and `le_b2_a`, are transparent and hold in the same way as the outbound paths, taking their input from the resolved B1 and B2 inputs.
- R6: Each `*_oe_n` is active low. When it is high, the matching `*_out` is 0 and `*_oe` is 0. When it is low, `*_oe` is 1. The three ports are enabled independently.
- R7: The resolved input of a port is `*_in` while `*_drv` is 1. Otherwise it is the last `*_in` seen on a clock edge with `*_drv` at 1. After reset it is 0.
- R8: After reset, all four paths hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_in | input | W | External value on port A |
| a_drv | input | 1 | An external driver is active on port A |
| b1_in | input | W | External value on port B1 |
| b1_drv | input | 1 | An external driver is active on port B1 |
| b2_in | input | W | External value on port B2 |
| b2_drv | input | 1 | An external driver is active on port B2 |
| le_a_b1 | input | 1 | Enable of the A-to-B1 path |
| le_a_b2 | input | 1 | Enable of the A-to-B2 path |
| le_b1_a | input | 1 | Enable of the B1-to-A path |
| le_b2_a | input | 1 | Enable of the B2-to-A path |
| a_src_b1 | input | 1 | 1: A sourced from B1 path, 0: from B2 path |
| a_oe_n | input | 1 | Active-low output enable, port A |
| b1_oe_n | input | 1 | Active-low output enable, port B1 |
| b2_oe_n | input | 1 | Active-low output enable, port B2 |
| a_out | output | W | Value driven on port A |
| a_oe | output | 1 | Port A is driving |
| b1_out | output | W | Value driven on port B1 |
| b1_oe | output | 1 | Port B1 is driving |
| b2_out | output | W | Value driven on port B2 |
| b2_oe | output | 1 | Port B2 is driving |

## Verification
Two events can fall in the same cycle. A keeper can release, with its driver flag dropping, in the cycle where a path that reads it is open or is closing. The path must then pass or capture the kept value and not the abandoned input. The sweep covers every combination of the four enables, the select and the three output enables, and it toggles the driver flags and the data word on each vector, so these collisions happen many times. A reference model in the bench is built from the requirements alone and judges every output port on every vector.

// File: rtl/bus_xchg3_pkg.sv
package bus_xchg3_pkg;
  localparam int XCHG_W = 12;
  typedef enum logic {
    SRC_B2 = 1'b0,
    SRC_B1 = 1'b1
  } a_src_e;
endpackage

// File: rtl/xchg_rst_sync.sv
module xchg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      rst_q_n  <= stage1_q;
    end
  end
endmodule

// File: rtl/xchg_keeper.sv
module xchg_keeper #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drv,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] val
);
  logic [W-1:0] keep_q, keep_d;

  always_comb begin
    keep_d = keep_q;
    if (drv) keep_d = pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= '0;
    else        keep_q <= keep_d;
  end

  assign val = drv ? pin_in : keep_q;

  // R7
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv |=> (val == $past(keep_q) || drv));
endmodule

// File: rtl/xchg_path.sv
module xchg_path #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] y
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (le) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  assign y = le ? d : q;

  // R2
  path_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> $stable(q));

  // R1
  path_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (q == $past(d)));
endmodule

// File: rtl/bus_xchg3.sv
module bus_xchg3
  import bus_xchg3_pkg::*;
#(
  parameter int W = XCHG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  input  logic [W-1:0] b1_in,
  input  logic         b1_drv,
  input  logic [W-1:0] b2_in,
  input  logic         b2_drv,
  input  logic         le_a_b1,
  input  logic         le_a_b2,
  input  logic         le_b1_a,
  input  logic         le_b2_a,
  input  logic         a_src_b1,
  input  logic         a_oe_n,
  input  logic         b1_oe_n,
  input  logic         b2_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  output logic [W-1:0] b2_out,
  output logic         b2_oe
);
  logic         rst_q_n;
  logic [W-1:0] a_val, b1_val, b2_val;
  logic [W-1:0] ab1_q, ab1_y, ab2_q, ab2_y;
  logic [W-1:0] b1a_q, b1a_y, b2a_q, b2a_y;
  logic [W-1:0] a_mux;
  a_src_e       a_src;

  xchg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  xchg_keeper #(.W(W)) u_keep_a  (.clk(clk), .rst_n(rst_q_n), .drv(a_drv),
                                  .pin_in(a_in),  .val(a_val));
  xchg_keeper #(.W(W)) u_keep_b1 (.clk(clk), .rst_n(rst_q_n), .drv(b1_drv),
                                  .pin_in(b1_in), .val(b1_val));
  xchg_keeper #(.W(W)) u_keep_b2 (.clk(clk), .rst_n(rst_q_n), .drv(b2_drv),
                                  .pin_in(b2_in), .val(b2_val));

  xchg_path #(.W(W)) u_ab1 (.clk(clk), .rst_n(rst_q_n), .le(le_a_b1),
                            .d(a_val),  .q(ab1_q), .y(ab1_y));
  xchg_path #(.W(W)) u_ab2 (.clk(clk), .rst_n(rst_q_n), .le(le_a_b2),
                            .d(a_val),  .q(ab2_q), .y(ab2_y));
  xchg_path #(.W(W)) u_b1a (.clk(clk), .rst_n(rst_q_n), .le(le_b1_a),
                            .d(b1_val), .q(b1a_q), .y(b1a_y));
  xchg_path #(.W(W)) u_b2a (.clk(clk), .rst_n(rst_q_n), .le(le_b2_a),
                            .d(b2_val), .q(b2a_q), .y(b2a_y));

  assign a_src = a_src_e'(a_src_b1);

  always_comb begin
    unique case (a_src)
      SRC_B1:  a_mux = b1a_y;
      default: a_mux = b2a_y;
    endcase
  end

  assign a_oe   = ~a_oe_n;
  assign b1_oe  = ~b1_oe_n;
  assign b2_oe  = ~b2_oe_n;
  assign a_out  = a_oe_n  ? '0 : a_mux;
  assign b1_out = b1_oe_n ? '0 : ab1_y;
  assign b2_out = b2_oe_n ? '0 : ab2_y;

  // R4
  a_sel_b1_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!a_oe_n && a_src_b1 && !le_b1_a) |-> (a_out == b1a_q));

  // R4
  a_sel_b2_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!a_oe_n && !a_src_b1 && !le_b2_a) |-> (a_out == b2a_q));

  // R6
  b1_float_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    b1_oe_n |-> (b1_out == '0 && !b1_oe));

  // R3
  fanout_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (le_a_b1 && le_a_b2 && !b1_oe_n && !b2_oe_n) |-> (b1_out == b2_out));
endmodule

// File: tb/bus_xchg3_bench.sv
module bus_xchg3_bench;
  localparam int W = 12;
  localparam logic [W-1:0] M = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, b1_in, b2_in;
  logic a_drv, b1_drv, b2_drv;
  logic le_a_b1, le_a_b2, le_b1_a, le_b2_a, a_src_b1;
  logic a_oe_n, b1_oe_n, b2_oe_n;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;

  int n_vec = 0;
  int n_bad = 0;

  logic [W-1:0] ka, kb1, kb2, qab1, qab2, qb1a, qb2a;

  always #4 clk = ~clk;

  bus_xchg3 #(.W(W)) u_bus_xchg3 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_drv(a_drv), .b1_in(b1_in), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_drv(b2_drv),
    .le_a_b1(le_a_b1), .le_a_b2(le_a_b2), .le_b1_a(le_b1_a), .le_b2_a(le_b2_a),
    .a_src_b1(a_src_b1), .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n),
    .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_out(b2_out), .b2_oe(b2_oe)
  );

  task automatic cmp(input string tag, input string nm,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [W-1:0] da,
                       input logic [W-1:0] d1, input logic [W-1:0] d2,
                       input logic [10:0] c);
    logic [W-1:0] ra, r1, r2, yab1, yab2, yb1a, yb2a, ea;
    @(negedge clk);
    a_in = da; b1_in = d1; b2_in = d2;
    {a_drv, b1_drv, b2_drv, le_a_b1, le_a_b2, le_b1_a, le_b2_a,
     a_src_b1, a_oe_n, b1_oe_n, b2_oe_n} = c;
    #1;
    ra = a_drv  ? da : ka;
    r1 = b1_drv ? d1 : kb1;
    r2 = b2_drv ? d2 : kb2;
    yab1 = le_a_b1 ? ra : qab1;
    yab2 = le_a_b2 ? ra : qab2;
    yb1a = le_b1_a ? r1 : qb1a;
    yb2a = le_b2_a ? r2 : qb2a;
    ea = a_src_b1 ? yb1a : yb2a;
    cmp(tag, "a_out",  a_out,  a_oe_n  ? '0 : ea);
    cmp(tag, "b1_out", b1_out, b1_oe_n ? '0 : yab1);
    cmp(tag, "b2_out", b2_out, b2_oe_n ? '0 : yab2);
    cmp("R6", "oe", {9'd0, a_oe, b1_oe, b2_oe},
        {9'd0, ~a_oe_n, ~b1_oe_n, ~b2_oe_n});
    @(posedge clk);
    ka = ra; kb1 = r1; kb2 = r2;
    qab1 = yab1; qab2 = yab2; qb1a = yb1a; qb2a = yb2a;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    {ka, kb1, kb2, qab1, qab2, qb1a, qb2a} = '0;
    a_in = '0; b1_in = '0; b2_in = '0;
    {a_drv, b1_drv, b2_drv, le_a_b1, le_a_b2, le_b1_a, le_b2_a, a_src_b1} = '0;
    {a_oe_n, b1_oe_n, b2_oe_n} = '1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R8: all paths and keepers empty after reset
    apply("R8", 12'h5A5, 12'h3C3, 12'h0F0, 11'b000_0000_1_000);
    apply("R8", 12'h5A5, 12'h3C3, 12'h0F0, 11'b000_0000_0_000);
    // R7: drive A, release, open both outbound paths
    apply("R7", 12'hABC, 12'h000, 12'h000, 11'b100_0000_0_111);
    apply("R7", 12'h123, 12'h000, 12'h000, 11'b000_1100_0_000);
    // R2: close A-to-B1, change A, B1 must hold ABC
    apply("R2", 12'h777, 12'h000, 12'h000, 11'b100_0100_0_000);
    apply("R2", 12'h999, 12'h000, 12'h000, 11'b100_0100_0_000);
    // R4: load B1 and B2 paths with distinct words, then select each
    apply("R4", 12'h000, 12'h111, 12'h222, 11'b011_0011_0_000);
    apply("R4", 12'h000, 12'h444, 12'h555, 11'b011_0000_1_000);
    apply("R4", 12'h000, 12'h444, 12'h555, 11'b011_0000_0_000);
    // R1/R3/R5/R6 sweep: every control combination, varying data and drivers
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [2:0] dv;
        dv = 3'((i * 5 + p * 3) >> 1);
        apply("R1/R3/R5", 12'((i * 37 + p * 911) & M),
              12'((i * 53 + 17) & M), 12'((i * 71 + p * 5 + 301) & M),
              {dv, 8'(i)});
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule